// File: doc/BRIEF.md
# Edge/Level Selectable Interrupt Request Latch

This block is the capture stage at the front of an eight-line interrupt controller. Each input line passes through a synchronizer. A per-line trigger-mode bit then decides how the line is turned into a pending request. In edge mode a request is latched on a low-to-high transition and stays set until acknowledge logic clears it. In level mode the request follows the line in both directions. The pending request vector feeds a priority resolver further down.

The trigger-mode register is one byte wide and is read and written through a simple register port. A per-instance parameter gives the bits that may ever be set; writes to the other bits are dropped, so those lines stay edge-triggered for good. A typical primary controller uses a writable mask of 0xF8 and a secondary one uses 0xDE. An initialization strobe clears the requests, the remembered line levels and the trigger-mode register. The writable mask is a parameter, so it is not affected. An 8-bit acknowledge-clear input lets in-service logic drop request bits.

Top module: `irq_trig_latch`

## Requirements
- R1: After synchronous reset, `req_out` is 0 and `cfg_rdata` is 0, so every line starts in edge mode.
- R2: A write on the register port stores `cfg_wdata & WR_MASK`. `cfg_rdata` shows the stored byte from the clock edge that takes the write onward. Bit i = 1 selects level mode for line i and bit i = 0 selects edge mode.
- R3: In level mode, `req_out[i]` is 1 while the synchronized line is high and 0 while it is low. A change on `irq_in` reaches `req_out` on the third rising edge after it is applied.
- R4: In edge mode, a low-to-high transition of the synchronized line sets `req_out[i]`. A later low level does not clear it.
- R5: In edge mode, a line held high sets its request only once. After an acknowledge clears the request, it stays 0 until the line goes low and then high again.
- R6: In edge mode, `ack_clr[i]` = 1 clears `req_out[i]` at the next edge. A new rising transition evaluated in that same cycle wins, and the bit stays set.
- R7: In level mode, `ack_clr[i]` = 1 forces `req_out[i]` to 0 for one cycle. If the line is still high, the bit is set again at the following edge.
- R8: `init_stb` clears the requests, the stored levels and the trigger-mode register at the next edge, and it wins over a write in the same cycle. Later writes are still filtered by `WR_MASK`.
- R9: After initialization, a line that is already high counts as a new edge, so its request is set at the edge after the initialization edge.
- R10: A trigger-mode write takes effect in the evaluation of the cycle after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Asynchronous interrupt lines |
| cfg_wr | input | 1 | Trigger-mode register write strobe |
| cfg_wdata | input | 8 | Trigger-mode write data |
| cfg_rdata | output | 8 | Stored trigger-mode register |
| init_stb | input | 1 | Initialization strobe |
| ack_clr | input | 8 | Per-line request clear from acknowledge logic |
| req_out | output | 8 | Pending request vector |

## Verification
A change on `irq_in` is due at `req_out` after three rising edges: two synchronizer stages plus the request register. Acknowledge, initialization and trigger-mode writes act on the first edge; a mode change alters request evaluation only from the second edge. The bench drives inputs just after a falling edge and samples on the falling edge after the counted number of rising edges. A bench reference, clocked on the same edges and derived from the requirements, is compared every cycle during the random phase.

// File: rtl/irql_pkg.sv
package irql_pkg;
    parameter int IRQL_LINES = 8;

    typedef logic [IRQL_LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t req;
        line_vec_t last;
    } core_state_t;
endpackage

// File: rtl/irql_sync.sv
module irql_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb pipe_d[s] = async_in;
            end else begin : g_rest
                always_comb pipe_d[s] = pipe_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign sync_out = pipe_q[STAGES-1];
endmodule

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
    parameter int                 WIDTH   = 8,
    parameter logic [WIDTH-1:0]   WR_MASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_stb,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mode
);
    logic [WIDTH-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (init_stb)  mode_d = '0;
        else if (wr)   mode_d = wdata & WR_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R2: a write lands masked
    a_r2_masked_write: assert property (@(posedge clk) disable iff (rst)
        (wr && !init_stb) |=> (mode_q == ($past(wdata) & WR_MASK)));
    // R8: initialization clears the mode register
    a_r8_init_mode: assert property (@(posedge clk) disable iff (rst)
        init_stb |=> (mode_q == '0));
    // R2: no update without a strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr && !init_stb) |=> $stable(mode_q));
endmodule

// File: rtl/irql_req_core.sv
module irql_req_core
    import irql_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_stb,
    input  line_vec_t line,
    input  line_vec_t mode,
    input  line_vec_t ack_clr,
    output line_vec_t req
);
    core_state_t st_d, st_q;
    line_vec_t   edge_req, lvl_req;

    always_comb begin
        // edge path: keep unless acknowledged, set on fresh rise
        edge_req = (st_q.req & ~ack_clr) | (line & ~st_q.last);
        // level path: follow the line, acknowledge masks one cycle
        lvl_req  = line & ~ack_clr;
        st_d.req  = (mode & lvl_req) | (~mode & edge_req);
        st_d.last = line;
        if (init_stb) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req = st_q.req;

    // R8: initialization clears requests and stored levels
    a_r8_init_core: assert property (@(posedge clk) disable iff (rst)
        init_stb |=> (st_q.req == '0 && st_q.last == '0));

    generate
        for (genvar i = 0; i < IRQL_LINES; i++) begin : g_chk
            // R4: edge-mode request persists without acknowledge
            a_r4_edge_hold: assert property (@(posedge clk) disable iff (rst)
                (!init_stb && !mode[i] && st_q.req[i] && !ack_clr[i]) |=> st_q.req[i]);
            // R3: level-mode request follows the line
            a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
                (!init_stb && mode[i]) |=> (st_q.req[i] == $past(line[i] & ~ack_clr[i])));
            // R5: a held-high edge line cannot re-set a cleared request
            a_r5_no_reset: assert property (@(posedge clk) disable iff (rst)
                (!init_stb && !mode[i] && !st_q.req[i] && st_q.last[i]) |=> !st_q.req[i]);
        end
    endgenerate
endmodule

// File: rtl/irq_trig_latch.sv
module irq_trig_latch
    import irql_pkg::*;
#(
    parameter logic [IRQL_LINES-1:0] WR_MASK     = 8'hF8,
    parameter int                    SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IRQL_LINES-1:0] irq_in,
    input  logic                  cfg_wr,
    input  logic [IRQL_LINES-1:0] cfg_wdata,
    output logic [IRQL_LINES-1:0] cfg_rdata,
    input  logic                  init_stb,
    input  logic [IRQL_LINES-1:0] ack_clr,
    output logic [IRQL_LINES-1:0] req_out
);
    line_vec_t line_s, mode_v;

    irql_sync #(.WIDTH(IRQL_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .sync_out (line_s)
    );

    irql_mode_reg #(.WIDTH(IRQL_LINES), .WR_MASK(WR_MASK)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .init_stb (init_stb),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .mode     (mode_v)
    );

    irql_req_core u_core (
        .clk      (clk),
        .rst      (rst),
        .init_stb (init_stb),
        .line     (line_s),
        .mode     (mode_v),
        .ack_clr  (ack_clr),
        .req      (req_out)
    );

    assign cfg_rdata = mode_v;

    // R1: reset state at the ports
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (req_out == '0 && cfg_rdata == '0));
    // R8: mode bits outside the mask never appear
    a_r8_mask_kept: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~WR_MASK) == '0);
endmodule

// File: tb/irq_trig_latch_test.sv
module irq_trig_latch_test;
    localparam logic [7:0] MASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       init_stb = 1'b0;
    logic [7:0] ack_clr = '0;
    logic [7:0] req_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0] m_s1 = '0, m_s2 = '0, m_mode = '0, m_req = '0, m_last = '0;

    always #4 clk = ~clk;

    irq_trig_latch #(.WR_MASK(MASK)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .init_stb(init_stb),
        .ack_clr(ack_clr), .req_out(req_out)
    );

    // next request per requirements R3..R7
    function automatic logic [7:0] next_req(input logic [7:0] md, rq, lst, ln, ak);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (md[i]) r[i] = ln[i] & ~ak[i];
            else       r[i] = (rq[i] & ~ak[i]) | (ln[i] & ~lst[i]);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_mode <= '0; m_req <= '0; m_last <= '0;
        end else begin
            m_s1 <= irq_in;
            m_s2 <= m_s1;
            if (init_stb) begin
                m_mode <= '0; m_req <= '0; m_last <= '0;
            end else begin
                if (cfg_wr) m_mode <= cfg_wdata & MASK;
                m_req  <= next_req(m_mode, m_req, m_last, m_s2, ack_clr);
                m_last <= m_s2;
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step(1);
        cfg_wr = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 req", req_out, 8'h00);
        check("R1 mode", cfg_rdata, 8'h00);
        // R2 masked writes
        write_mode(8'hFF);
        check("R2 mask FF", cfg_rdata, 8'hF8);
        write_mode(8'h05);
        check("R2 mask 05", cfg_rdata, 8'h00);
        // R3 level line 4
        write_mode(8'h10);
        irq_in[4] = 1'b1;
        step(2);
        check("R3 not yet", req_out, 8'h00);
        step(1);
        check("R3 rise", req_out, 8'h10);
        irq_in[4] = 1'b0;
        step(3);
        check("R3 fall", req_out, 8'h00);
        // R4 edge line 5
        irq_in[5] = 1'b1;
        step(3);
        check("R4 rise", req_out, 8'h20);
        irq_in[5] = 1'b0;
        step(3);
        check("R4 low keeps", req_out, 8'h20);
        // R6 ack clears edge request
        ack_clr = 8'h20;
        step(1);
        ack_clr = '0;
        check("R6 ack", req_out, 8'h00);
        // R5 held high sets once
        irq_in[5] = 1'b1;
        step(3);
        check("R5 set", req_out, 8'h20);
        ack_clr = 8'h20;
        step(1);
        ack_clr = '0;
        step(4);
        check("R5 held", req_out, 8'h00);
        // R7 level ack
        irq_in[4] = 1'b1;
        step(3);
        check("R7 level high", req_out & 8'h10, 8'h10);
        ack_clr = 8'h10;
        step(1);
        ack_clr = '0;
        check("R7 cleared", req_out & 8'h10, 8'h00);
        step(1);
        check("R7 reset again", req_out & 8'h10, 8'h10);
        irq_in = '0;
        step(3);
        // R10 mode write effective one cycle later
        irq_in[7] = 1'b1;
        step(3);
        ack_clr = 8'h80;
        step(1);
        ack_clr = '0;
        check("R10 cleared", req_out & 8'h80, 8'h00);
        write_mode(8'h90);
        check("R10 old mode", req_out & 8'h80, 8'h00);
        step(1);
        check("R10 new mode", req_out & 8'h80, 8'h80);
        // R8 init
        init_stb = 1'b1;
        step(1);
        init_stb = 1'b0;
        check("R8 req", req_out, 8'h00);
        check("R8 mode", cfg_rdata, 8'h00);
        // R9 held line counts as new edge
        step(1);
        check("R9 re-edge", req_out & 8'h80, 8'h80);
        write_mode(8'hFF);
        check("R8 mask kept", cfg_rdata, 8'hF8);
        cfg_wr = 1'b1; cfg_wdata = 8'hF0; init_stb = 1'b1;
        step(1);
        cfg_wr = 1'b0; init_stb = 1'b0;
        check("R8 init wins", cfg_rdata, 8'h00);

        // random phase against reference
        irq_in = '0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        void'($urandom(32'd1234));
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 3) == 0) irq_in = irq_in ^ (8'(1) << $urandom_range(0, 7));
            cfg_wr    = ($urandom_range(0, 19) == 0);
            cfg_wdata = 8'($urandom);
            ack_clr   = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
            init_stb  = ($urandom_range(0, 199) == 0);
            step(1);
            check("R3 R4 R5 R6 R7 random req", req_out, m_req);
            check("R2 R8 random mode", cfg_rdata, m_mode);
        end
        cfg_wr = 1'b0; ack_clr = '0; init_stb = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule